// File: doc/BRIEF.md
# Mixed-Rule Two-State Cellular Automaton Array

This block holds a fixed rectangular grid of two-state cells (16 by 16 by default) and advances them in lockstep, one generation per enabled clock. Each cell has its own rule selector, a small index into a shared table of rules. Each rule is a pair of nine-bit masks over the live-neighbour count: one for birth, one for survival. Different regions of the grid can therefore follow different life-like rules at the same time. For example, a wire built from cells that are born on one neighbour, flanked by cells that are born on two, carries a travelling pulse across a background that never changes.

Software-free operation is assumed. A host writes cells one at a time through a load port and rewrites rule table entries through a table port. It then either pulses `step` for single generations or holds `run` to advance on every clock. The whole grid is visible at all times on a flat readout bus. Writes of either kind are taken only while the array is not advancing.

Top module: `mixrule_ca_array`

## Requirements
- R1: After reset every cell reads dead and every cell selects table entry 0. The table holds these presets, where mask bit n stands for a neighbour count of n:
  - entry 0: never born, never survives;
  - entry 1: born on 3, survives on 2 or 3;
  - entry 2: born on 1, never survives;
  - entry 3: born on 2, never survives;
  - entry 4: born on 1 or 2, survives on 1;
  - entries 5 to 7: all-zero masks.
- R2: With `run` and `step` low, `load_en` writes `load_alive` and `load_rule` into the cell at (`load_row`, `load_col`). The readout shows the new state one cycle later, and the new rule index governs the next generation. Cell (r,c) appears on `grid_q` bit r*COLS+c.
- R3: A load or a table write presented in a cycle where `run` or `step` is high is discarded. That cycle's generation is computed as if the write were absent.
- R4: A cell's neighbour count is the number of live cells among its eight Moore neighbours. Positions outside the array count as dead, with no wraparound at the edges.
- R5: On an advance, a dead cell becomes live exactly when bit `count` of its rule's birth mask is set. A live cell stays live exactly when bit `count` of its survival mask is set. Every other cell is dead afterwards.
- R6: All cells update at the same clock edge, using only the states from before that edge.
- R7: With `run` low, each clock cycle in which `step` is high advances exactly one generation.
- R8: While `run` is high, the array advances one generation on every clock cycle.
- R9: With `run` and `step` low, `tbl_we` replaces entry `tbl_idx` with {`tbl_birth`, `tbl_surv`}. Every cell selecting that entry uses the new masks from the next advance on.
- R10: Cells selecting preset entry 1 follow standard two-state life. For example, a line of three live cells flips between horizontal and vertical every generation.
- R11: A three-row wire has a middle row of entry-2 cells with an entry-3 row above and below it. A live middle cell whose left neighbours in the outer rows are live moves one column to the right per generation, with its two outer-row tails one column behind it.
- R12: When there is no advance and no accepted write, the grid and all rule selectors hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load_en | input | 1 | Write one cell (idle only) |
| load_row | input | RW (4) | Row of the cell to write |
| load_col | input | CW (4) | Column of the cell to write |
| load_alive | input | 1 | State to write |
| load_rule | input | IW (3) | Rule table index to write |
| tbl_we | input | 1 | Write one rule table entry (idle only) |
| tbl_idx | input | IW (3) | Entry to write |
| tbl_birth | input | 9 | Birth mask, bit n = count n |
| tbl_surv | input | 9 | Survival mask, bit n = count n |
| step | input | 1 | Advance one generation in this cycle |
| run | input | 1 | Advance every cycle while high |
| grid_q | output | ROWS*COLS (256) | Current states, bit r*COLS+c |

## Verification
Every cell state is visible on `grid_q`, so a wrong next-state value shows up on the readout one cycle after the edge that produced it. It then spreads to the neighbouring cells one ring per generation. A corrupted rule selector or table entry stays hidden until an advance reaches a neighbour count whose mask bit differs. For this reason the bench sweeps pseudo-random mixed-rule grids over many generations and compares the whole grid after every one. Edge handling and discarded writes are exposed by patterns whose result would differ in the very next generation.

// File: rtl/ca_pkg.sv
package ca_pkg;

  localparam int MASK_W = 9;

  typedef struct packed {
    logic [MASK_W-1:0] birth;
    logic [MASK_W-1:0] surv;
  } rule_t;

  // Reset contents of the rule table, bit n of a mask = neighbour count n
  function automatic rule_t preset_rule(input int idx);
    rule_t r;
    r = '0;
    case (idx)
      1: begin r.birth = 9'b0_0000_1000; r.surv = 9'b0_0000_1100; end
      2: begin r.birth = 9'b0_0000_0010; r.surv = 9'b0_0000_0000; end
      3: begin r.birth = 9'b0_0000_0100; r.surv = 9'b0_0000_0000; end
      4: begin r.birth = 9'b0_0000_0110; r.surv = 9'b0_0000_0010; end
      default: r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/ca_rule_table.sv
module ca_rule_table
  import ca_pkg::*;
#(
  parameter int IW = 3,
  localparam int ENTRIES = 1 << IW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  rule_t         wr_rule,
  output rule_t         tbl_o [ENTRIES]
);

  rule_t tbl_q [ENTRIES];
  rule_t tbl_d [ENTRIES];

  always_comb begin
    tbl_d = tbl_q;
    if (wr_en) tbl_d[wr_idx] = wr_rule;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) tbl_q[i] <= preset_rule(i);
    end else if (wr_en) begin
      tbl_q <= tbl_d;
    end
  end

  assign tbl_o = tbl_q;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_chk
    // R9
    tbl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx == IW'(e)) |=> tbl_q[e] == $past(wr_rule));
    // R3
    tbl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_idx == IW'(e)) |=> $stable(tbl_q[e]));
  end

endmodule

// File: rtl/ca_cell.sv
module ca_cell
  import ca_pkg::*;
#(
  parameter int IW = 3,
  localparam int ENTRIES = 1 << IW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv_i,
  input  logic          ld_i,
  input  logic          ld_alive_i,
  input  logic [IW-1:0] ld_rule_i,
  input  logic [8:0]    nbr_i,
  input  rule_t         tbl_i [ENTRIES],
  output logic          alive_o
);

  logic          alive_q, alive_d;
  logic [IW-1:0] rule_q, rule_d;
  logic [3:0]    cnt;
  rule_t         cur;
  logic          en;

  assign cnt = 4'($countones(nbr_i));
  assign cur = tbl_i[rule_q];
  assign en  = ld_i | adv_i;

  always_comb begin
    alive_d = alive_q;
    rule_d  = rule_q;
    if (ld_i) begin
      alive_d = ld_alive_i;
      rule_d  = ld_rule_i;
    end else if (adv_i) begin
      alive_d = alive_q ? cur.surv[cnt] : cur.birth[cnt];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alive_q <= 1'b0;
      rule_q  <= '0;
    end else if (en) begin
      alive_q <= alive_d;
      rule_q  <= rule_d;
    end
  end

  assign alive_o = alive_q;

  // R2
  cell_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_i |=> (alive_q == $past(ld_alive_i)) && (rule_q == $past(ld_rule_i)));
  // R12
  cell_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_i && !adv_i) |=> $stable(alive_q) && $stable(rule_q));
  // R5
  cell_noborn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !ld_i && !alive_q && cur.birth == '0) |=> !alive_q);
  // R6
  cell_rule_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !ld_i) |=> $stable(rule_q));

endmodule

// File: rtl/mixrule_ca_array.sv
module mixrule_ca_array
  import ca_pkg::*;
#(
  parameter int ROWS = 16,
  parameter int COLS = 16,
  parameter int IW   = 3,
  localparam int ENTRIES = 1 << IW,
  localparam int CELLS   = ROWS * COLS,
  localparam int RW      = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CW      = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [RW-1:0]    load_row,
  input  logic [CW-1:0]    load_col,
  input  logic             load_alive,
  input  logic [IW-1:0]    load_rule,
  input  logic             tbl_we,
  input  logic [IW-1:0]    tbl_idx,
  input  logic [8:0]       tbl_birth,
  input  logic [8:0]       tbl_surv,
  input  logic             step,
  input  logic             run,
  output logic [CELLS-1:0] grid_q
);

  logic [1:0]       rst_pipe;
  logic             rst_int_n;
  logic             adv;
  logic             ld_ok;
  logic             tbl_ok;
  rule_t            wr_rule;
  rule_t            tbl [ENTRIES];
  logic [CELLS-1:0] alive;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  assign adv     = run | step;
  assign ld_ok   = load_en & ~adv;
  assign tbl_ok  = tbl_we & ~adv;
  assign wr_rule = '{birth: tbl_birth, surv: tbl_surv};

  ca_rule_table #(.IW(IW)) u_table (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (tbl_ok),
    .wr_idx  (tbl_idx),
    .wr_rule (wr_rule),
    .tbl_o   (tbl)
  );

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      logic [8:0] nb;
      logic       hit;
      for (genvar k = 0; k < 9; k++) begin : g_nb
        localparam int NR = r + k / 3 - 1;
        localparam int NC = c + k % 3 - 1;
        if (k == 4 || NR < 0 || NR >= ROWS || NC < 0 || NC >= COLS) begin : g_off
          assign nb[k] = 1'b0;
        end else begin : g_on
          assign nb[k] = alive[NR*COLS + NC];
        end
      end
      assign hit = ld_ok && (load_row == RW'(r)) && (load_col == CW'(c));

      ca_cell #(.IW(IW)) u_cell (
        .clk        (clk),
        .rst_n      (rst_int_n),
        .adv_i      (adv),
        .ld_i       (hit),
        .ld_alive_i (load_alive),
        .ld_rule_i  (load_rule),
        .nbr_i      (nb),
        .tbl_i      (tbl),
        .alive_o    (alive[r*COLS + c])
      );
    end
  end

  assign grid_q = alive;

  // R3
  busy_grid_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!adv && !ld_ok) |=> $stable(grid_q));
  // R1
  reset_grid_chk: assert property (@(posedge clk)
    !rst_int_n |-> grid_q == '0);

endmodule

// File: tb/mixrule_ca_array_tb.sv
module mixrule_ca_array_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int ROWS = 16;
  localparam int COLS = 16;
  localparam int IW   = 3;
  localparam int ENT  = 1 << IW;
  localparam int CELLS = ROWS * COLS;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             load_en = 1'b0;
  logic [3:0]       load_row = '0;
  logic [3:0]       load_col = '0;
  logic             load_alive = 1'b0;
  logic [IW-1:0]    load_rule = '0;
  logic             tbl_we = 1'b0;
  logic [IW-1:0]    tbl_idx = '0;
  logic [8:0]       tbl_birth = '0;
  logic [8:0]       tbl_surv = '0;
  logic             step = 1'b0;
  logic             run = 1'b0;
  logic [CELLS-1:0] grid_q;

  int n_checks = 0;
  int n_fail   = 0;

  bit         m_st [ROWS][COLS];
  int         m_rl [ROWS][COLS];
  logic [8:0] m_b  [ENT];
  logic [8:0] m_s  [ENT];
  int unsigned seed = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  mixrule_ca_array #(.ROWS(ROWS), .COLS(COLS), .IW(IW)) dut_i (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_row(load_row),
    .load_col(load_col), .load_alive(load_alive), .load_rule(load_rule),
    .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_birth(tbl_birth),
    .tbl_surv(tbl_surv), .step(step), .run(run), .grid_q(grid_q)
  );

  function automatic int unsigned rnd();
    seed ^= seed << 13;
    seed ^= seed >> 17;
    seed ^= seed << 5;
    return seed;
  endfunction

  task automatic model_gen();
    bit nx [ROWS][COLS];
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS; c++) begin
        int n = 0;
        for (int dr = -1; dr <= 1; dr++) begin
          for (int dc = -1; dc <= 1; dc++) begin
            int rr = r + dr;
            int cc = c + dc;
            if ((dr != 0 || dc != 0) && rr >= 0 && rr < ROWS && cc >= 0 && cc < COLS)
              n += int'(m_st[rr][cc]);
          end
        end
        nx[r][c] = m_st[r][c] ? m_s[m_rl[r][c]][n] : m_b[m_rl[r][c]][n];
      end
    end
    m_st = nx;
  endtask

  function automatic logic [CELLS-1:0] model_vec();
    logic [CELLS-1:0] v;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        v[r*COLS+c] = m_st[r][c];
    return v;
  endfunction

  task automatic check_vec(input string tag, input logic [CELLS-1:0] exp);
    n_checks++;
    if (grid_q !== exp) begin
      n_fail++;
      $display("FAIL %s: grid actual %h expected %h", tag, grid_q, exp);
    end
  endtask

  task automatic check_model(input string tag);
    check_vec(tag, model_vec());
  endtask

  task automatic load_cell(input int r, input int c, input bit a, input int rl);
    load_en = 1'b1; load_row = 4'(r); load_col = 4'(c);
    load_alive = a; load_rule = IW'(rl);
    @(negedge clk);
    load_en = 1'b0;
    m_st[r][c] = a; m_rl[r][c] = rl;
  endtask

  task automatic write_tbl(input int idx, input logic [8:0] b, input logic [8:0] s);
    tbl_we = 1'b1; tbl_idx = IW'(idx); tbl_birth = b; tbl_surv = s;
    @(negedge clk);
    tbl_we = 1'b0;
    m_b[idx] = b; m_s[idx] = s;
  endtask

  task automatic do_step();
    step = 1'b1;
    @(negedge clk);
    step = 1'b0;
    model_gen();
  endtask

  task automatic do_run(input int k);
    run = 1'b1;
    repeat (k) @(negedge clk);
    run = 1'b0;
    for (int i = 0; i < k; i++) model_gen();
  endtask

  task automatic clear_all(input int rl);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        load_cell(r, c, 1'b0, rl);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    m_b[0] = 9'h000; m_s[0] = 9'h000;
    m_b[1] = 9'h008; m_s[1] = 9'h00C;
    m_b[2] = 9'h002; m_s[2] = 9'h000;
    m_b[3] = 9'h004; m_s[3] = 9'h000;
    m_b[4] = 9'h006; m_s[4] = 9'h002;
    for (int i = 5; i < ENT; i++) begin m_b[i] = '0; m_s[i] = '0; end
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin m_st[r][c] = 1'b0; m_rl[r][c] = 0; end

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check_vec("R1 reset grid", '0);
    // R1 presets: background cells with a live seed do nothing
    load_cell(4, 4, 1'b1, 0);
    check_model("R2 single load");
    do_step();
    check_model("R1 entry0 background dies");

    // R10 blinker in the middle under preset entry 1
    clear_all(1);
    load_cell(8, 7, 1'b1, 1); load_cell(8, 8, 1'b1, 1); load_cell(8, 9, 1'b1, 1);
    repeat (3) @(negedge clk);
    check_model("R12 idle hold");
    for (int g = 0; g < 4; g++) begin
      do_step();
      check_model("R10 R7 blinker step");
    end
    begin
      logic [CELLS-1:0] e = '0;
      e[8*COLS+7] = 1'b1; e[8*COLS+8] = 1'b1; e[8*COLS+9] = 1'b1;
      check_vec("R10 blinker period two", e);
    end

    // R4 edges: birth on zero; a corner seed would wrap otherwise
    write_tbl(5, 9'h001, 9'h000);
    clear_all(5);
    load_cell(0, 0, 1'b1, 5);
    do_step();
    check_model("R4 R9 birth-on-zero with corner seed");
    begin
      logic [CELLS-1:0] e = '1;
      e[0] = 1'b0; e[1] = 1'b0; e[COLS] = 1'b0; e[COLS+1] = 1'b0;
      check_vec("R4 no wraparound", e);
    end
    // R4 glider into the corner with life rule
    clear_all(1);
    load_cell(0, 1, 1'b1, 1); load_cell(1, 2, 1'b1, 1);
    load_cell(2, 0, 1'b1, 1); load_cell(2, 1, 1'b1, 1); load_cell(2, 2, 1'b1, 1);
    load_cell(15, 15, 1'b1, 1); load_cell(15, 14, 1'b1, 1); load_cell(14, 15, 1'b1, 1);
    for (int g = 0; g < 6; g++) begin
      do_step();
      check_model("R4 R5 edge patterns");
    end

    // R11 wire pulse along rows 5..7
    clear_all(0);
    for (int c = 0; c < COLS; c++) begin
      load_cell(5, c, 1'b0, 3); load_cell(6, c, 1'b0, 2); load_cell(7, c, 1'b0, 3);
    end
    load_cell(6, 2, 1'b1, 2); load_cell(5, 1, 1'b1, 3); load_cell(7, 1, 1'b1, 3);
    do_run(10);
    begin
      logic [CELLS-1:0] e = '0;
      e[6*COLS+12] = 1'b1; e[5*COLS+11] = 1'b1; e[7*COLS+11] = 1'b1;
      check_vec("R11 R8 pulse after ten generations", e);
    end
    check_model("R11 model");

    // R3 load and table write discarded while advancing
    clear_all(1);
    load_cell(3, 3, 1'b1, 1); load_cell(3, 4, 1'b1, 1); load_cell(3, 5, 1'b1, 1);
    run = 1'b1; load_en = 1'b1; load_row = 4'd10; load_col = 4'd10;
    load_alive = 1'b1; load_rule = 3'd1;
    @(negedge clk);
    run = 1'b0; load_en = 1'b0;
    model_gen();
    check_model("R3 load during run");
    step = 1'b1; tbl_we = 1'b1; tbl_idx = 3'd1; tbl_birth = 9'h1FF; tbl_surv = 9'h1FF;
    load_en = 1'b1; load_row = 4'd12; load_col = 4'd12;
    @(negedge clk);
    step = 1'b0; tbl_we = 1'b0; load_en = 1'b0;
    model_gen();
    check_model("R3 writes during step");
    do_step();
    check_model("R3 table unchanged after busy write");

    // R9 idle table write changes live behaviour of entry 1
    write_tbl(1, 9'h048, 9'h00C);
    clear_all(1);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        if (rnd() % 3 == 0) load_cell(r, c, 1'b1, 1);
    for (int g = 0; g < 5; g++) begin
      do_step();
      check_model("R9 rewritten entry");
    end

    // R5 R6 mixed-rule pseudo-random sweep over all entries
    write_tbl(6, 9'h1E0, 9'h1F0);
    write_tbl(7, 9'h010, 9'h100);
    for (int pass = 0; pass < 3; pass++) begin
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++)
          load_cell(r, c, bit'(rnd() % 2), int'(rnd() % ENT));
      check_model("R2 full load");
      for (int g = 0; g < 12; g++) begin
        if (g % 2 == 0) do_step(); else do_run(1 + g % 3);
        check_model("R5 R6 R7 R8 mixed sweep");
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule